// File: doc/BRIEF.md
# Read Latency Data Scheduler

This block sits in the read path of a memory controller or a memory model. It decides in which half clock cycle read data and the read strobe become valid after a READ command is taken on a rising clock edge. The delay between command and first data beat is programmable in half clock cycles, so a delay of two and a half clocks is possible. Data then runs at two beats per clock, one on the rising and one on the falling half.

The output is split into two lanes per clock: a rise lane and a fall lane. Each lane has a data-valid bit, a strobe-enable bit and a beat index. The beat index tells the data path which word of the burst belongs to that half cycle. All lanes are registered. The values present after rising edge `e` describe half-slot `2e` (rise lane) and half-slot `2e+1` (fall lane).

The schedule is kept in a shift line of half-cycle slots that advances two slots per clock. A small phase machine follows the head of that line and has three states. `ST_IDLE`: nothing is scheduled. `ST_PENDING`: slots are scheduled, but none is at the head yet. `ST_STREAM`: the head pair holds a strobe or data slot. On every edge the machine takes one of the following transitions, decided from the next slot contents:
- to `ST_STREAM` when the head pair will be active;
- to `ST_PENDING` when only later slots are active;
- to `ST_IDLE` when no slot is active.

The lanes are driven only in `ST_STREAM`.

Top module: `read_latency_scheduler`

## Requirements
- R1: During and right after reset, all lane outputs and `cfg_err` are 0.
- R2: A READ is taken at rising edge n when `rd_cmd` is 1. Latency code 2'b00 means 2 clocks, 2'b01 means 2.5 clocks and 2'b10 means 3 clocks. The first beat occupies half-slot 2n+4, 2n+5 or 2n+6 respectively. For 2.5 clocks this is the fall lane after edge n+2.
- R3: Burst code 2'b00 gives 2 beats, 2'b01 gives 4 beats and 2'b10 gives 8 beats. Data-valid is high in exactly that many consecutive half-slots.
- R4: Within a burst, the beat index runs 0, 1, 2, … in half-slot order, with the rise lane before the fall lane of the same clock.
- R5: Strobe-enable is high in the two half-slots just before the first beat (one clock of preamble) and in every data half-slot. It is low when nothing is scheduled.
- R6: A READ taken exactly burst/2 clocks after the previous one, with the same latency, keeps data-valid high with no gap between the two bursts.
- R7: A READ taken while an older burst is still scheduled wins from its own first beat onward. Older beats that would fall at or after that half-slot are dropped. Older beats before it are kept.
- R8: A READ with latency code 2'b11 or burst code 2'b11 schedules nothing and sets `cfg_err`.
- R9: `cfg_err` stays 1 until reset. Valid READs taken after it is set are still scheduled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | READ command strobe |
| lat_code | input | 2 | Latency select (see R2) |
| burst_code | input | 2 | Burst length select (see R3) |
| rise_valid | output | 1 | Data beat in the rising half-slot |
| fall_valid | output | 1 | Data beat in the falling half-slot |
| rise_strobe_en | output | 1 | Strobe driven in the rising half-slot |
| fall_strobe_en | output | 1 | Strobe driven in the falling half-slot |
| rise_beat | output | 3 | Burst word index for the rising half-slot |
| fall_beat | output | 3 | Burst word index for the falling half-slot |
| cfg_err | output | 1 | Sticky flag for a READ with a reserved code |

## Verification
The bench builds the block with its default parameters: six half-slots of maximum latency and eight-beat maximum bursts, which gives a fourteen-slot line. With this line, the longest burst at the longest latency fills the last slot, so the end of the line is exercised. Short bursts behind long ones reach the cancellation path, where older beats beyond a new burst's end are cleared. The half-cycle code is used both alone and mixed with whole-cycle codes in consecutive reads, so bursts that start on the fall lane can meet bursts that start on the rise lane.

// File: rtl/rdsched_pkg.sv
package rdsched_pkg;

    // width of the beat index carried with each slot
    parameter int BEAT_W = 3;

    typedef struct packed {
        logic              data;
        logic              strb;
        logic [BEAT_W-1:0] beat;
    } slot_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PENDING = 2'd1,
        ST_STREAM  = 2'd2
    } phase_e;

endpackage

// File: rtl/rdsched_decode.sv
module rdsched_decode
    import rdsched_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [1:0]      lat_code,
    input  logic [1:0]      burst_code,
    output logic [IW-1:0]   lat_half,
    output logic [BEAT_W:0] burst_len,
    output logic            code_ok
);

    logic lat_ok;
    logic len_ok;

    // latency in half cycles: 2, 2.5 and 3 clocks
    always_comb begin
        lat_ok = 1'b1;
        case (lat_code)
            2'b00:   lat_half = IW'(4);
            2'b01:   lat_half = IW'(5);
            2'b10:   lat_half = IW'(6);
            default: begin
                lat_half = '0;
                lat_ok   = 1'b0;
            end
        endcase
    end

    // number of beats per burst
    always_comb begin
        len_ok = 1'b1;
        case (burst_code)
            2'b00:   burst_len = (BEAT_W+1)'(2);
            2'b01:   burst_len = (BEAT_W+1)'(4);
            2'b10:   burst_len = (BEAT_W+1)'(8);
            default: begin
                burst_len = '0;
                len_ok    = 1'b0;
            end
        endcase
    end

    assign code_ok = lat_ok & len_ok;

endmodule

// File: rtl/rdsched_slots.sv
module rdsched_slots
    import rdsched_pkg::*;
#(
    parameter int W  = 14,
    parameter int IW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins,
    input  logic [IW-1:0]   lat_half,
    input  logic [BEAT_W:0] burst_len,
    output slot_t           head_rise,
    output slot_t           head_fall,
    output logic [W-1:0]    act_next
);

    slot_t q   [W];
    slot_t nxt [W];

    // advance two half-slots per clock, then overlay a new burst
    always_comb begin
        for (int i = 0; i < W; i++) nxt[i] = '0;
        for (int i = 0; i < W - 2; i++) nxt[i] = q[i+2];
        if (ins) begin
            for (int i = 0; i < W; i++) begin
                if (i >= int'(lat_half)) begin
                    if (i < int'(lat_half) + int'(burst_len)) begin
                        nxt[i].data = 1'b1;
                        nxt[i].strb = 1'b1;
                        nxt[i].beat = BEAT_W'(i - int'(lat_half));
                    end else begin
                        // the new burst cuts off anything older behind it
                        nxt[i] = '0;
                    end
                end else if (i + 2 >= int'(lat_half)) begin
                    // one clock of strobe preamble
                    nxt[i].strb = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < W; i++) q[i] <= '0;
        end else begin
            for (int i = 0; i < W; i++) q[i] <= nxt[i];
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_act
        assign act_next[g] = nxt[g].data | nxt[g].strb;
    end

    assign head_rise = q[0];
    assign head_fall = q[1];

    // R2: an accepted READ lands beat 0 exactly at its latency slot
    a_r2_first_beat_lands: assert property (
        @(posedge clk) disable iff (!rst_n)
        ins |=> (q[$past(lat_half)].data && q[$past(lat_half)].beat == '0)
    );

    // R5: the slot just ahead of a fresh first beat carries preamble strobe
    a_r5_preamble_slot: assert property (
        @(posedge clk) disable iff (!rst_n)
        ins |=> q[$past(lat_half) - IW'(1)].strb
    );

endmodule

// File: rtl/read_latency_scheduler.sv
module read_latency_scheduler
    import rdsched_pkg::*;
#(
    parameter int MAX_LAT_HALF = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic [1:0]        lat_code,
    input  logic [1:0]        burst_code,
    output logic              rise_valid,
    output logic              fall_valid,
    output logic              rise_strobe_en,
    output logic              fall_strobe_en,
    output logic [BEAT_W-1:0] rise_beat,
    output logic [BEAT_W-1:0] fall_beat,
    output logic              cfg_err
);

    localparam int MAX_BURST = 1 << BEAT_W;
    localparam int W         = MAX_LAT_HALF + MAX_BURST;
    localparam int IW        = $clog2(W);

    logic [IW-1:0]   lat_half;
    logic [BEAT_W:0] burst_len;
    logic            code_ok;
    logic            ins;
    logic            err_q;
    slot_t           head_rise;
    slot_t           head_fall;
    logic [W-1:0]    act_next;
    phase_e          state_q;
    phase_e          state_d;

    rdsched_decode #(.IW(IW)) u_decode (
        .lat_code  (lat_code),
        .burst_code(burst_code),
        .lat_half  (lat_half),
        .burst_len (burst_len),
        .code_ok   (code_ok)
    );

    assign ins = rd_cmd & code_ok;

    rdsched_slots #(.W(W), .IW(IW)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins      (ins),
        .lat_half (lat_half),
        .burst_len(burst_len),
        .head_rise(head_rise),
        .head_fall(head_fall),
        .act_next (act_next)
    );

    // phase transitions follow the next slot contents
    always_comb begin
        if (|act_next[1:0])  state_d = ST_STREAM;
        else if (|act_next)  state_d = ST_PENDING;
        else                 state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_q | (rd_cmd & ~code_ok);
        end
    end

    // lanes are driven only while streaming
    always_comb begin
        rise_valid     = 1'b0;
        fall_valid     = 1'b0;
        rise_strobe_en = 1'b0;
        fall_strobe_en = 1'b0;
        rise_beat      = '0;
        fall_beat      = '0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_PENDING: ;
            ST_STREAM: begin
                rise_valid     = head_rise.data;
                fall_valid     = head_fall.data;
                rise_strobe_en = head_rise.strb;
                fall_strobe_en = head_fall.strb;
                rise_beat      = head_rise.beat;
                fall_beat      = head_fall.beat;
            end
            default: ;
        endcase
    end

    assign cfg_err = err_q;

    // R9: the error flag never clears outside reset
    a_r9_err_sticky: assert property (
        @(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err
    );

    // R8: a READ with a reserved code raises the flag
    a_r8_reserved_flags: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rd_cmd && !code_ok) |=> cfg_err
    );

    // R5: every data half-slot has the strobe enabled
    a_r5_rise_strobe_with_data: assert property (
        @(posedge clk) disable iff (!rst_n)
        rise_valid |-> rise_strobe_en
    );
    a_r5_fall_strobe_with_data: assert property (
        @(posedge clk) disable iff (!rst_n)
        fall_valid |-> fall_strobe_en
    );

    // R4: inside a burst the fall lane follows the rise lane by one beat
    a_r4_beat_step: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rise_valid && fall_valid && fall_beat != '0) |-> (fall_beat == rise_beat + 1'b1)
    );

    // R1: nothing leaves the block while idle
    a_r1_idle_quiet: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !(rise_valid || fall_valid || rise_strobe_en || fall_strobe_en)
    );

endmodule

// File: tb/tb_read_latency_scheduler.sv
module tb_read_latency_scheduler;

    localparam int SLOTS = 14;
    localparam int NSLOT = 4096;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rd_cmd;
    logic [1:0] lat_code;
    logic [1:0] burst_code;
    logic       rise_valid, fall_valid, rise_strobe_en, fall_strobe_en;
    logic [2:0] rise_beat, fall_beat;
    logic       cfg_err;

    read_latency_scheduler dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_cmd        (rd_cmd),
        .lat_code      (lat_code),
        .burst_code    (burst_code),
        .rise_valid    (rise_valid),
        .fall_valid    (fall_valid),
        .rise_strobe_en(rise_strobe_en),
        .fall_strobe_en(fall_strobe_en),
        .rise_beat     (rise_beat),
        .fall_beat     (fall_beat),
        .cfg_err       (cfg_err)
    );

    always #10 clk = ~clk;  // 50 MHz

    int    total = 0;
    int    bad = 0;
    int    edge_cnt = 0;
    int    err_edge = 0;
    bit    running = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // scoreboard: expected content per absolute half-slot
    bit ev [NSLOT];
    bit es [NSLOT];
    int eb [NSLOT];

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, expv);
        end
    endtask

    // driver: presents one READ and records what it must produce
    task automatic issue(input logic [1:0] lc, input logic [1:0] bc);
        int n, lh, bl, s0;
        rd_cmd     = 1'b1;
        lat_code   = lc;
        burst_code = bc;
        n  = edge_cnt + 1;
        lh = (lc == 2'd0) ? 4 : (lc == 2'd1) ? 5 : (lc == 2'd2) ? 6 : -1;
        bl = (bc == 2'd0) ? 2 : (bc == 2'd1) ? 4 : (bc == 2'd2) ? 8 : -1;
        if (lh < 0 || bl < 0) begin
            if (err_edge == 0) err_edge = n;
        end else begin
            s0 = 2 * n + lh;
            es[s0-2] = 1'b1;
            es[s0-1] = 1'b1;
            for (int k = 0; k < bl; k++) begin
                ev[s0+k] = 1'b1;
                es[s0+k] = 1'b1;
                eb[s0+k] = k;
            end
            for (int s = s0 + bl; s < 2 * n + SLOTS; s++) begin
                ev[s] = 1'b0;
                es[s] = 1'b0;
                eb[s] = 0;
            end
        end
        @(negedge clk);
        rd_cmd = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // monitor: compares both lanes against the scoreboard each clock
    always @(negedge clk) begin
        if (running) begin
            int sr, sf;
            sr = 2 * edge_cnt;
            sf = sr + 1;
            chk(rise_valid == ev[sr], cur_tag, "rise_valid", int'(rise_valid), int'(ev[sr]));
            chk(fall_valid == ev[sf], cur_tag, "fall_valid", int'(fall_valid), int'(ev[sf]));
            chk(rise_strobe_en == es[sr], cur_tag, "rise_strobe_en", int'(rise_strobe_en), int'(es[sr]));
            chk(fall_strobe_en == es[sf], cur_tag, "fall_strobe_en", int'(fall_strobe_en), int'(es[sf]));
            if (ev[sr]) chk(int'(rise_beat) == eb[sr], cur_tag, "rise_beat", int'(rise_beat), eb[sr]);
            if (ev[sf]) chk(int'(fall_beat) == eb[sf], cur_tag, "fall_beat", int'(fall_beat), eb[sf]);
            chk(cfg_err == (err_edge != 0 && edge_cnt >= err_edge), cur_tag, "cfg_err",
                int'(cfg_err), int'(err_edge != 0 && edge_cnt >= err_edge));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog %s act=%0d exp=%0d", cur_tag, edge_cnt, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        rd_cmd     = 1'b0;
        lat_code   = 2'd0;
        burst_code = 2'd0;
        idle(3);
        // R1: quiet outputs held in reset
        cur_tag = "R1";
        chk(!(rise_valid | fall_valid | rise_strobe_en | fall_strobe_en), "R1", "lanes in reset",
            int'(rise_valid | fall_valid | rise_strobe_en | fall_strobe_en), 0);
        chk(cfg_err == 1'b0, "R1", "cfg_err in reset", int'(cfg_err), 0);
        rst_n   = 1'b1;
        running = 1'b1;
        idle(2);

        // R2 R3 R4 R5: each latency code with each burst length
        cur_tag = "R2 R3 R4 R5";
        issue(2'd0, 2'd1);
        idle(8);
        issue(2'd1, 2'd2);
        idle(10);
        issue(2'd2, 2'd0);
        idle(8);
        issue(2'd2, 2'd2);
        idle(10);

        // R6: back-to-back reads spaced by half a burst
        cur_tag = "R6";
        issue(2'd1, 2'd1);
        idle(1);
        issue(2'd1, 2'd1);
        idle(1);
        issue(2'd0, 2'd0);
        issue(2'd0, 2'd0);
        issue(2'd0, 2'd0);
        idle(10);

        // R7: a later read cuts into an older long burst
        cur_tag = "R7";
        issue(2'd0, 2'd2);
        idle(1);
        issue(2'd0, 2'd0);
        idle(12);
        issue(2'd2, 2'd2);
        issue(2'd1, 2'd0);
        idle(12);

        // R8: reserved latency and burst codes schedule nothing
        cur_tag = "R8";
        issue(2'd3, 2'd1);
        idle(6);
        issue(2'd0, 2'd3);
        idle(6);

        // R9: flag stays set, good reads still run
        cur_tag = "R9";
        issue(2'd1, 2'd2);
        idle(14);

        running = 1'b0;
        done    = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule